// File: doc/BRIEF.md
# Privileged Control Register Access Checker

This block judges each system-register read or write aimed at a 64-bit hypervisor control register and holds that register. For every request it weighs the current privilege level, whether the hypervisor level is enabled, two nested-virtualization flags, the monitor level's presence and its trap-lower control, and the halted/secure-debug-disabled status. It then returns one of five outcomes: complete, undefined, trap to the hypervisor level, trap to the monitor level, or redirect to memory at a fixed byte offset.

The surrounding pipeline presents one request per cycle on `req_valid`. One clock later the block answers with `rsp_valid`, a one-hot outcome, the trap syndrome class when a trap is taken, the memory offset when the access is redirected, and the read data when a read completes. The stored control bits are also driven out continuously so that neighbouring logic can use them. Performing the memory access and entering the exception are left to the caller.

Top module: `pcr_access_gate`

## Requirements
- R1: After reset the stored control word is zero, `rsp_valid` is 0 and `outcome` is zero.
- R2: A request accepted at a clock edge is answered at the next edge with `rsp_valid`=1 and exactly one `outcome` bit set (bit 0 complete, bit 1 undefined, bit 2 trap to hypervisor, bit 3 trap to monitor, bit 4 redirect). A cycle without a request yields `rsp_valid`=0 and `outcome`=0.
- R3: Every access made at level 0 (`cur_level`=0, user) is undefined.
- R4: At level 1 (kernel), when the hypervisor is enabled and both `nest_base` and `nest_redir` are 1, the outcome is redirect and `mem_offset` is 0x930.
- R5: At level 1, when the hypervisor is enabled, `nest_base`=1 and `nest_redir`=0, the access traps. It goes to the monitor if `mon_present` and `mon_trap_lower` are both 1, and to the hypervisor otherwise. All other level-1 cases are undefined.
- R6: At level 2 (hypervisor), the access traps to the monitor when `mon_present` and `mon_trap_lower` are both 1, and completes otherwise.
- R7: At level 3 (monitor), the access always completes, whatever the other inputs are.
- R8: Whenever a monitor trap would be chosen while `halted` and `sec_dbg_off` are both 1, the outcome is undefined instead.
- R9: Both trap outcomes report `syndrome`=0x18. `syndrome` is 0 for non-trap outcomes and `mem_offset` is 0 for non-redirect outcomes.
- R10: Only bits 31, 8, 1 and 0 of the control word can be written. All other bits are stored and read as zero.
- R11: A write changes the control word only when its outcome is complete. `rdata` is the control word for a completed read and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| cur_level | input | 2 | Privilege level, 0 user to 3 monitor |
| hyp_en | input | 1 | Hypervisor level enabled in current state |
| nest_base | input | 1 | Nested-virtualization trap flag |
| nest_redir | input | 1 | Nested-virtualization redirect flag |
| mon_present | input | 1 | Monitor level implemented |
| mon_trap_lower | input | 1 | Monitor traps lower-level accesses |
| halted | input | 1 | Core is in debug halt |
| sec_dbg_off | input | 1 | Secure debug disabled |
| wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid |
| outcome | output | 5 | One-hot outcome |
| syndrome | output | 6 | Trap syndrome class |
| mem_offset | output | 12 | Byte offset for redirected access |
| rdata | output | 64 | Read data |
| ctrl_bits | output | 64 | Stored control word |

## Verification
The bench builds the block with its default parameters: a 64-bit word, the writable mask on bits 31, 8, 1 and 0, redirect offset 0x930 and syndrome class 0x18. Every privilege level, and every branch of the trap and redirect priority, is therefore reachable with directed requests. Writing all ones at the monitor level shows the writable mask directly. Writes issued with non-complete outcomes are followed by reads, which show the word was left unchanged.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int OUT_N      = 5;
  localparam int O_DONE     = 0;
  localparam int O_UNDEF    = 1;
  localparam int O_TRAP_HYP = 2;
  localparam int O_TRAP_MON = 3;
  localparam int O_REDIR    = 4;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } level_e;

  typedef struct packed {
    logic hyp_en;
    logic nest_base;
    logic nest_redir;
    logic mon_present;
    logic mon_trap_lower;
    logic halted;
    logic sec_dbg_off;
  } ctx_t;
endpackage

// File: rtl/pcr_outcome_decide.sv
module pcr_outcome_decide
  import pcr_pkg::*;
(
  input  level_e           lvl,
  input  ctx_t             ctx,
  output logic [OUT_N-1:0] onehot
);
  logic mon_trap;
  logic dbg_block;
  logic [OUT_N-1:0] mon_or_undef;

  assign mon_trap  = ctx.mon_present & ctx.mon_trap_lower;
  assign dbg_block = ctx.halted & ctx.sec_dbg_off;

  always_comb begin
    mon_or_undef = '0;
    if (dbg_block) mon_or_undef[O_UNDEF]    = 1'b1;
    else           mon_or_undef[O_TRAP_MON] = 1'b1;
  end

  always_comb begin
    onehot = '0;
    unique case (lvl)
      LVL_USER: onehot[O_UNDEF] = 1'b1;
      LVL_KERNEL: begin
        if (ctx.hyp_en && ctx.nest_base && ctx.nest_redir)
          onehot[O_REDIR] = 1'b1;
        else if (ctx.hyp_en && ctx.nest_base) begin
          if (mon_trap) onehot = mon_or_undef;
          else          onehot[O_TRAP_HYP] = 1'b1;
        end else
          onehot[O_UNDEF] = 1'b1;
      end
      LVL_HYP: begin
        if (mon_trap) onehot = mon_or_undef;
        else          onehot[O_DONE] = 1'b1;
      end
      default: onehot[O_DONE] = 1'b1;
    endcase
  end
endmodule

// File: rtl/pcr_ctrl_store.sv
module pcr_ctrl_store #(
  parameter int                DATA_W  = 64,
  parameter logic [DATA_W-1:0] WR_MASK = 64'h0000_0000_8000_0103
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata & WR_MASK;
  end
endmodule

// File: rtl/pcr_rsp_stage.sv
module pcr_rsp_stage
  import pcr_pkg::*;
#(
  parameter int               DATA_W       = 64,
  parameter int               OFF_W        = 12,
  parameter int               CLS_W        = 6,
  parameter logic [OFF_W-1:0] REDIR_OFFSET = 12'h930,
  parameter logic [CLS_W-1:0] TRAP_CLASS   = 6'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OUT_N-1:0]  onehot_d,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic              rsp_valid,
  output logic [OUT_N-1:0]  outcome,
  output logic [CLS_W-1:0]  syndrome,
  output logic [OFF_W-1:0]  mem_offset,
  output logic [DATA_W-1:0] rdata
);
  logic is_trap;
  logic rd_done;

  assign is_trap = onehot_d[O_TRAP_HYP] | onehot_d[O_TRAP_MON];
  assign rd_done = !req_write && onehot_d[O_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      outcome    <= '0;
      syndrome   <= '0;
      mem_offset <= '0;
      rdata      <= '0;
    end else begin
      rsp_valid  <= req_valid;
      outcome    <= req_valid ? onehot_d : '0;
      syndrome   <= (req_valid && is_trap) ? TRAP_CLASS : '0;
      mem_offset <= (req_valid && onehot_d[O_REDIR]) ? REDIR_OFFSET : '0;
      rdata      <= (req_valid && rd_done) ? ctrl_q : '0;
    end
  end
endmodule

// File: rtl/pcr_access_gate.sv
module pcr_access_gate
  import pcr_pkg::*;
#(
  parameter int                DATA_W       = 64,
  parameter int                OFF_W        = 12,
  parameter int                CLS_W        = 6,
  parameter logic [DATA_W-1:0] WR_MASK      = 64'h0000_0000_8000_0103,
  parameter logic [OFF_W-1:0]  REDIR_OFFSET = 12'h930,
  parameter logic [CLS_W-1:0]  TRAP_CLASS   = 6'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        cur_level,
  input  logic              hyp_en,
  input  logic              nest_base,
  input  logic              nest_redir,
  input  logic              mon_present,
  input  logic              mon_trap_lower,
  input  logic              halted,
  input  logic              sec_dbg_off,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [4:0]        outcome,
  output logic [CLS_W-1:0]  syndrome,
  output logic [OFF_W-1:0]  mem_offset,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_bits
);
  ctx_t             ctx;
  logic [OUT_N-1:0] onehot_d;
  logic             wr_en;

  assign ctx = '{hyp_en: hyp_en, nest_base: nest_base, nest_redir: nest_redir,
                 mon_present: mon_present, mon_trap_lower: mon_trap_lower,
                 halted: halted, sec_dbg_off: sec_dbg_off};

  pcr_outcome_decide u_decide (
    .lvl    (level_e'(cur_level)),
    .ctx    (ctx),
    .onehot (onehot_d)
  );

  assign wr_en = req_valid & req_write & onehot_d[O_DONE];

  pcr_ctrl_store #(.DATA_W(DATA_W), .WR_MASK(WR_MASK)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wdata (wdata),
    .q     (ctrl_bits)
  );

  pcr_rsp_stage #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .CLS_W(CLS_W),
    .REDIR_OFFSET(REDIR_OFFSET), .TRAP_CLASS(TRAP_CLASS)
  ) u_rsp (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .onehot_d   (onehot_d),
    .ctrl_q     (ctrl_bits),
    .rsp_valid  (rsp_valid),
    .outcome    (outcome),
    .syndrome   (syndrome),
    .mem_offset (mem_offset),
    .rdata      (rdata)
  );
endmodule

// File: rtl/pcr_access_gate_chk.sv
module pcr_access_gate_chk #(
  parameter int                DATA_W     = 64,
  parameter int                CLS_W      = 6,
  parameter logic [DATA_W-1:0] WR_MASK    = 64'h0000_0000_8000_0103,
  parameter logic [CLS_W-1:0]  TRAP_CLASS = 6'h18
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        cur_level,
  input logic              halted,
  input logic              sec_dbg_off,
  input logic              rsp_valid,
  input logic [4:0]        outcome,
  input logic [CLS_W-1:0]  syndrome,
  input logic [DATA_W-1:0] ctrl_bits
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && outcome == '0)); // R2
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones(outcome) == 1)); // R2
  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_level == 2'd0) |=> outcome[1]); // R3
  AST_MON_LEVEL_DONE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_level == 2'd3) |=> outcome[0]); // R7
  AST_DBG_NO_MON_TRAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && halted && sec_dbg_off) |=> !outcome[3]); // R8
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (outcome[2] || outcome[3])) |-> syndrome == TRAP_CLASS); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits & ~WR_MASK) == '0); // R10
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> $stable(ctrl_bits)); // R11
  AST_NOT_DONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !outcome[0]) |-> $stable(ctrl_bits)); // R11
endmodule

bind pcr_access_gate pcr_access_gate_chk #(
  .DATA_W(DATA_W), .CLS_W(CLS_W), .WR_MASK(WR_MASK), .TRAP_CLASS(TRAP_CLASS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .cur_level(cur_level), .halted(halted), .sec_dbg_off(sec_dbg_off),
  .rsp_valid(rsp_valid), .outcome(outcome), .syndrome(syndrome),
  .ctrl_bits(ctrl_bits)
);

// File: tb/pcr_access_gate_bench.sv
module pcr_access_gate_bench;
  localparam logic [4:0] E_DONE = 5'b00001;
  localparam logic [4:0] E_UND  = 5'b00010;
  localparam logic [4:0] E_THYP = 5'b00100;
  localparam logic [4:0] E_TMON = 5'b01000;
  localparam logic [4:0] E_RED  = 5'b10000;
  localparam logic [63:0] MASK  = 64'h0000_0000_8000_0103;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] cur_level = 2'd0;
  logic hyp_en = 1'b0, nest_base = 1'b0, nest_redir = 1'b0;
  logic mon_present = 1'b0, mon_trap_lower = 1'b0, halted = 1'b0, sec_dbg_off = 1'b0;
  logic [63:0] wdata = '0;
  logic rsp_valid;
  logic [4:0] outcome;
  logic [5:0] syndrome;
  logic [11:0] mem_offset;
  logic [63:0] rdata, ctrl_bits;

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] model_ctrl = '0;

  always #5 clk = ~clk;

  pcr_access_gate u_pcr_access_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .cur_level(cur_level), .hyp_en(hyp_en), .nest_base(nest_base),
    .nest_redir(nest_redir), .mon_present(mon_present),
    .mon_trap_lower(mon_trap_lower), .halted(halted), .sec_dbg_off(sec_dbg_off),
    .wdata(wdata), .rsp_valid(rsp_valid), .outcome(outcome), .syndrome(syndrome),
    .mem_offset(mem_offset), .rdata(rdata), .ctrl_bits(ctrl_bits)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ctx = {hyp_en, nest_base, nest_redir, mon_present, mon_trap_lower, halted, sec_dbg_off}
  task automatic access(input string tag, input logic [1:0] lvl, input logic [6:0] ctx,
                        input logic wr, input logic [63:0] data, input logic [4:0] exp_out);
    logic [5:0]  exp_syn;
    logic [11:0] exp_off;
    logic [63:0] exp_rd;
    @(negedge clk);
    cur_level = lvl;
    {hyp_en, nest_base, nest_redir, mon_present, mon_trap_lower, halted, sec_dbg_off} = ctx;
    req_write = wr; wdata = data; req_valid = 1'b1;
    exp_syn = (exp_out == E_THYP || exp_out == E_TMON) ? 6'h18 : 6'h00;
    exp_off = (exp_out == E_RED) ? 12'h930 : 12'h000;
    exp_rd  = (!wr && exp_out == E_DONE) ? model_ctrl : 64'h0;
    if (wr && exp_out == E_DONE) model_ctrl = data & MASK;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 rsp_valid"}, {63'h0, rsp_valid}, 64'h1);
    check({tag, " outcome"}, {59'h0, outcome}, {59'h0, exp_out});
    check({tag, " R9 syndrome"}, {58'h0, syndrome}, {58'h0, exp_syn});
    check({tag, " R9 mem_offset"}, {52'h0, mem_offset}, {52'h0, exp_off});
    check({tag, " R11 rdata"}, rdata, exp_rd);
    check({tag, " R11 ctrl_bits"}, ctrl_bits, model_ctrl);
  endtask

  task automatic t_reset();
    check("R1 ctrl after reset", ctrl_bits, 64'h0);
    check("R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    check("R1 outcome after reset", {59'h0, outcome}, 64'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R2 idle rsp_valid", {63'h0, rsp_valid}, 64'h0);
    check("R2 idle outcome", {59'h0, outcome}, 64'h0);
  endtask

  task automatic t_monitor();
    access("R7 R10 mon write ones", 2'd3, 7'b1111111, 1'b1, '1, E_DONE);
    check("R10 writable mask", ctrl_bits, 64'h8000_0103);
    access("R7 mon read", 2'd3, 7'b0001100, 1'b0, '0, E_DONE);
  endtask

  task automatic t_user();
    access("R3 user write", 2'd0, 7'b1110000, 1'b1, '0, E_UND);
    access("R3 user read", 2'd0, 7'b0000000, 1'b0, '0, E_UND);
  endtask

  task automatic t_hyp();
    access("R6 hyp write done", 2'd2, 7'b1000000, 1'b1, 64'h1, E_DONE);
    access("R6 hyp mon trap write", 2'd2, 7'b1001100, 1'b1, 64'hFFFF, E_TMON);
    access("R6 hyp trap-lower no mon", 2'd2, 7'b1000100, 1'b0, '0, E_DONE);
    access("R8 hyp halted sdd", 2'd2, 7'b1001111, 1'b1, '1, E_UND);
    access("R8 hyp halted only", 2'd2, 7'b1001110, 1'b0, '0, E_TMON);
  endtask

  task automatic t_kernel();
    access("R4 kernel redirect write", 2'd1, 7'b1110000, 1'b1, '1, E_RED);
    access("R4 kernel redirect over trap", 2'd1, 7'b1111100, 1'b0, '0, E_RED);
    access("R5 kernel trap hyp", 2'd1, 7'b1100000, 1'b1, '1, E_THYP);
    access("R5 kernel trap mon", 2'd1, 7'b1101100, 1'b0, '0, E_TMON);
    access("R5 kernel mon absent", 2'd1, 7'b1100100, 1'b0, '0, E_THYP);
    access("R8 kernel halted sdd", 2'd1, 7'b1101111, 1'b1, '1, E_UND);
    access("R5 kernel no hyp", 2'd1, 7'b0110000, 1'b1, '1, E_UND);
    access("R5 kernel redir flag only", 2'd1, 7'b1010000, 1'b0, '0, E_UND);
    access("R5 kernel no flags", 2'd1, 7'b1000000, 1'b0, '0, E_UND);
    access("R11 final read", 2'd3, 7'b0000000, 1'b0, '0, E_DONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_monitor();
    t_idle();
    t_user();
    t_hyp();
    t_kernel();
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule